// File: doc/BRIEF.md
# External Memory Bus Stretch Controller

This block sequences one external data-memory read or write on a multiplexed address/data bus. A request is accepted when the block is idle. On acceptance the block captures the address, the write data, the direction, a 3-bit stretch code, a 2-bit clock-divider mode and a page-hit flag. It then steps through up to four bus phases and ends with a one-clock completion pulse.

The phases are:

- the address latch phase, which is left out on a page hit;
- a setup phase before the strobe;
- the strobe phase, with the read or write strobe active;
- a hold phase after the strobe.

Each phase length is a number of ticks. A tick is one, two, four or `SLOW_TICK` system clocks, depending on the divider mode.

The stretch code selects a number of stretch cycles: 0, 1, 2, 3, 7, 8, 9 or 10. One stretch cycle is four ticks. Small codes add one tick of setup and one tick of hold and widen the strobe. Large codes add two stretch cycles of setup and one stretch cycle of hold. On a page miss, large codes also widen the address latch pulse by one stretch cycle. The block drives the latch enable, the two strobes, the address and data output enables, and the captured address and data.

Top module: `xbus_stretch_ctrl`

## Requirements
- R1: Stretch code 0 gives setup, strobe and hold phases of 1 tick each.
- R2: Stretch codes 1, 2 and 3 give a setup phase of 2 ticks and a hold phase of 2 ticks. The strobe phase is 2, 4 and 6 ticks respectively.
- R3: Stretch codes 4, 5, 6 and 7 give a setup phase of 9 ticks and a hold phase of 5 ticks. The strobe phase is 8, 10, 12 and 14 ticks respectively.
- R4: On a page miss, `ale_o` is high for 1 tick with codes 0 to 3 and for 5 ticks with codes 4 to 7. On a page hit, `ale_o` stays low and the setup phase starts in the first clock after acceptance.
- R5: A tick lasts 1, 2, 4 or `SLOW_TICK` clocks for `clk_mode_i` = 00, 01, 10 or 11. The mode and the stretch code are sampled only when a request is accepted.
- R6: `rd_o` (reads, `we_i`=0) or `wr_o` (writes, `we_i`=1) is high exactly during the strobe phase. The two strobes are never high together, and neither is high with `ale_o`.
- R7: `data_oe_o` stays low for a read. For a write it is high for exactly the strobe and hold phases.
- R8: `addr_oe_o` is high from the first access phase through the end of hold. During the access, `addr_o` and `wdata_o` carry the values captured at acceptance.
- R9: `done_o` is high for exactly one clock, in the clock after the hold phase ends. `busy_o` is high from the clock after acceptance through that clock and low afterwards.
- R10: A `start_i` that arrives while `busy_o` is high is ignored. It does not change the captured values, the phase lengths or the end of the access.
- R11: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Access request, accepted when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Access address |
| wdata_i | input | DW | Write data |
| page_hit_i | input | 1 | Upper address matches the previous access |
| stretch_i | input | 3 | Stretch code |
| clk_mode_i | input | 2 | Divider mode selecting clocks per tick |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-clock completion pulse |
| ale_o | output | 1 | Address latch enable |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| addr_oe_o | output | 1 | Address bus output enable |
| data_oe_o | output | 1 | Data bus output enable |
| addr_o | output | AW | Captured address |
| wdata_o | output | DW | Captured write data |

## Verification
Each phase is timed by counting clocks per output state.

- Code 0 is run in three divider modes, which separates tick scaling from stretch.
- Every small and large code is run, which exposes any error in the non-linear code-to-length map and in the uneven split between setup and hold.
- Page hits and misses are compared for small and large codes. This shows whether the latch pulse is removed, or widened only on a long-stretch miss.
- A request injected mid-access with a different mode, code, direction and address shows whether sampling happens only at acceptance.

// File: rtl/xbus_stretch_pkg.sv
package xbus_stretch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ALE, ST_SETUP, ST_STROBE, ST_HOLD, ST_DONE
  } phase_e;

  localparam int unsigned TICK_W   = 5;
  localparam int unsigned MAX_TICK = 14;
  localparam int unsigned N_PHASE  = 4;

  // non-linear map: upper half of codes jumps to 7..10
  function automatic logic [3:0] stretch_count(input logic [2:0] code);
    return code[2] ? ({1'b0, code} + 4'd3) : {1'b0, code};
  endfunction

  function automatic logic [TICK_W-1:0] setup_ticks(input logic [3:0] s);
    if (s == 4'd0)      return 5'd1;
    else if (s < 4'd4)  return 5'd2;
    else                return 5'd9;   // base + two stretch cycles
  endfunction

  function automatic logic [TICK_W-1:0] strobe_ticks(input logic [3:0] s);
    if (s == 4'd0)      return 5'd1;
    else if (s < 4'd4)  return {s, 1'b0};
    else                return {s, 1'b0} - 5'd6;
  endfunction

  function automatic logic [TICK_W-1:0] hold_ticks(input logic [3:0] s);
    if (s == 4'd0)      return 5'd1;
    else if (s < 4'd4)  return 5'd2;
    else                return 5'd5;   // base + one stretch cycle
  endfunction

  function automatic logic [TICK_W-1:0] ale_ticks(input logic [3:0] s, input logic hit);
    if (hit)            return 5'd0;
    else if (s < 4'd4)  return 5'd1;
    else                return 5'd5;
  endfunction

endpackage

// File: rtl/xbus_phase_len.sv
module xbus_phase_len
  import xbus_stretch_pkg::*;
#(
  parameter int unsigned SLOW_TICK = 4096,
  parameter int unsigned CW        = 16
) (
  input  logic [2:0]    code_i,
  input  logic [1:0]    mode_i,
  input  logic          hit_i,
  output logic [CW-1:0] ale_len_o,
  output logic [CW-1:0] setup_len_o,
  output logic [CW-1:0] strobe_len_o,
  output logic [CW-1:0] hold_len_o
);

  logic [3:0]        scnt;
  logic [CW-1:0]     tick_clks;
  logic [TICK_W-1:0] ticks [N_PHASE];
  logic [CW-1:0]     lens  [N_PHASE];

  assign scnt = stretch_count(code_i);

  always_comb begin
    unique case (mode_i)
      2'b00:   tick_clks = CW'(1);
      2'b01:   tick_clks = CW'(2);
      2'b10:   tick_clks = CW'(4);
      default: tick_clks = CW'(SLOW_TICK);
    endcase
  end

  assign ticks[0] = ale_ticks(scnt, hit_i);
  assign ticks[1] = setup_ticks(scnt);
  assign ticks[2] = strobe_ticks(scnt);
  assign ticks[3] = hold_ticks(scnt);

  for (genvar p = 0; p < N_PHASE; p++) begin : g_scale
    assign lens[p] = CW'(ticks[p]) * tick_clks;
  end

  assign ale_len_o    = lens[0];
  assign setup_len_o  = lens[1];
  assign strobe_len_o = lens[2];
  assign hold_len_o   = lens[3];

endmodule

// File: rtl/xbus_phase_cnt.sv
module xbus_phase_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          last_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_stretch_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          hit_i,
  input  logic [CW-1:0] ale_len_i,
  input  logic [CW-1:0] setup_len_i,
  input  logic [CW-1:0] strobe_len_i,
  input  logic [CW-1:0] hold_len_i,
  input  logic          last_i,
  output phase_e        state_o,
  output logic          accept_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o
);

  phase_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        accept_o = 1'b1;
        load_o   = 1'b1;
        if (hit_i) begin
          state_d    = ST_SETUP;
          load_val_o = setup_len_i - 1'b1;
        end else begin
          state_d    = ST_ALE;
          load_val_o = ale_len_i - 1'b1;
        end
      end
      ST_ALE: if (last_i) begin
        state_d    = ST_SETUP;
        load_o     = 1'b1;
        load_val_o = setup_len_i - 1'b1;
      end
      ST_SETUP: if (last_i) begin
        state_d    = ST_STROBE;
        load_o     = 1'b1;
        load_val_o = strobe_len_i - 1'b1;
      end
      ST_STROBE: if (last_i) begin
        state_d    = ST_HOLD;
        load_o     = 1'b1;
        load_val_o = hold_len_i - 1'b1;
      end
      ST_HOLD: if (last_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // every phase is entered with a freshly loaded count
  assert_phase_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_DONE && state_q != state_d && state_d != ST_DONE)
      |-> load_o);

  // strobe phase is always preceded by setup
  assert_setup_before_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_STROBE) |-> $past(state_q) == ST_SETUP);

endmodule

// File: rtl/xbus_stretch_ctrl.sv
module xbus_stretch_ctrl
  import xbus_stretch_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 8,
  parameter int unsigned SLOW_TICK = 4096
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          page_hit_i,
  input  logic [2:0]    stretch_i,
  input  logic [1:0]    clk_mode_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          ale_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          addr_oe_o,
  output logic          data_oe_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);

  localparam int unsigned CW = $clog2(MAX_TICK * SLOW_TICK + 1);

  phase_e        state;
  logic          accept, load, last;
  logic [CW-1:0] load_val;
  logic [CW-1:0] ale_len, setup_len, strobe_len, hold_len;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          we_q, hit_q;
  logic [2:0]    code_q;
  logic [1:0]    mode_q;

  logic [2:0]    code_sel;
  logic [1:0]    mode_sel;
  logic          hit_sel;

  // live config while idle, captured config once an access runs
  assign code_sel = busy_o ? code_q : stretch_i;
  assign mode_sel = busy_o ? mode_q : clk_mode_i;
  assign hit_sel  = busy_o ? hit_q  : page_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      hit_q   <= 1'b0;
      code_q  <= '0;
      mode_q  <= '0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      we_q    <= we_i;
      hit_q   <= page_hit_i;
      code_q  <= stretch_i;
      mode_q  <= clk_mode_i;
    end
  end

  xbus_phase_len #(.SLOW_TICK(SLOW_TICK), .CW(CW)) u_len (
    .code_i       (code_sel),
    .mode_i       (mode_sel),
    .hit_i        (hit_sel),
    .ale_len_o    (ale_len),
    .setup_len_o  (setup_len),
    .strobe_len_o (strobe_len),
    .hold_len_o   (hold_len)
  );

  xbus_phase_cnt #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  xbus_seq #(.CW(CW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .hit_i        (page_hit_i),
    .ale_len_i    (ale_len),
    .setup_len_i  (setup_len),
    .strobe_len_i (strobe_len),
    .hold_len_i   (hold_len),
    .last_i       (last),
    .state_o      (state),
    .accept_o     (accept),
    .load_o       (load),
    .load_val_o   (load_val)
  );

  assign busy_o    = (state != ST_IDLE);
  assign done_o    = (state == ST_DONE);
  assign ale_o     = (state == ST_ALE);
  assign rd_o      = (state == ST_STROBE) && !we_q;
  assign wr_o      = (state == ST_STROBE) &&  we_q;
  assign addr_oe_o = (state == ST_ALE) || (state == ST_SETUP) ||
                     (state == ST_STROBE) || (state == ST_HOLD);
  assign data_oe_o = we_q && ((state == ST_STROBE) || (state == ST_HOLD));
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;

  assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o) && !(ale_o && (rd_o || wr_o)));

  assert_read_no_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> !data_oe_o);

  assert_drive_in_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> addr_oe_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  assert_done_after_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(addr_oe_o) && !$past(rd_o || wr_o || ale_o));

  assert_busy_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(addr_o) && $stable(wdata_o));

endmodule

// File: tb/sim_xbus_stretch_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_stretch_ctrl;

  localparam int SLOW = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, we_i = 1'b0, page_hit_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [2:0]  stretch_i = '0;
  logic [1:0]  clk_mode_i = '0;
  logic        busy_o, done_o, ale_o, rd_o, wr_o, addr_oe_o, data_oe_o;
  logic [15:0] addr_o;
  logic [7:0]  wdata_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xbus_stretch_ctrl #(.AW(16), .DW(8), .SLOW_TICK(SLOW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .page_hit_i(page_hit_i),
    .stretch_i(stretch_i), .clk_mode_i(clk_mode_i),
    .busy_o(busy_o), .done_o(done_o), .ale_o(ale_o), .rd_o(rd_o), .wr_o(wr_o),
    .addr_oe_o(addr_oe_o), .data_oe_o(data_oe_o), .addr_o(addr_o), .wdata_o(wdata_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tick_of(input int mode);
    case (mode)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return SLOW;
    endcase
  endfunction

  // expected ticks per requirement tables
  function automatic int exp_setup(input int c);
    if (c == 0) return 1;   // R1
    if (c < 4)  return 2;   // R2
    return 9;               // R3
  endfunction
  function automatic int exp_strobe(input int c);
    case (c)
      0: return 1; 1: return 2; 2: return 4; 3: return 6;
      4: return 8; 5: return 10; 6: return 12; default: return 14;
    endcase
  endfunction
  function automatic int exp_hold(input int c);
    if (c == 0) return 1;
    if (c < 4)  return 2;
    return 5;
  endfunction
  function automatic int exp_ale(input int c, input bit hit);
    if (hit)   return 0;
    if (c < 4) return 1;
    return 5;
  endfunction

  task automatic access(input int code, input int mode, input bit hit, input bit we,
                        input logic [15:0] a, input logic [7:0] d,
                        input bit interfere, input string req);
    int n_ale, n_su, n_stb, n_hd, n_doe, bad, k, q;
    bit seen;
    n_ale = 0; n_su = 0; n_stb = 0; n_hd = 0; n_doe = 0; bad = 0; k = 0; seen = 0;
    q = tick_of(mode);
    start_i = 1'b1; we_i = we; addr_i = a; wdata_i = d; page_hit_i = hit;
    stretch_i = 3'(code); clk_mode_i = 2'(mode);
    @(negedge clk);
    start_i = 1'b0;
    if (hit) check(!ale_o && addr_oe_o, {req, " R4 hit skips latch"}, ale_o, 0);
    while (!done_o && k < 100000) begin
      if (ale_o) n_ale++;
      else if (rd_o || wr_o) begin n_stb++; seen = 1; end
      else if (addr_oe_o) begin if (seen) n_hd++; else n_su++; end
      if (data_oe_o) n_doe++;
      if ((rd_o && wr_o) || (rd_o && we) || (wr_o && !we)) bad++;
      if (!busy_o) bad++;
      if (interfere && k == 2) begin
        start_i = 1'b1; addr_i = ~a; wdata_i = ~d; we_i = ~we;
        stretch_i = 3'(7 - code); clk_mode_i = 2'(3 - mode); page_hit_i = ~hit;
      end
      k++;
      @(negedge clk);
    end
    check(done_o, {req, " R9 done reached"}, done_o, 1);
    start_i = 1'b0;
    check(n_ale == exp_ale(code, hit) * q, {req, " R4 ale clocks"}, n_ale, exp_ale(code, hit) * q);
    check(n_su  == exp_setup(code) * q,  {req, " setup clocks R5"}, n_su, exp_setup(code) * q);
    check(n_stb == exp_strobe(code) * q, {req, " strobe clocks R5"}, n_stb, exp_strobe(code) * q);
    check(n_hd  == exp_hold(code) * q,   {req, " hold clocks R5"}, n_hd, exp_hold(code) * q);
    check(n_doe == (we ? (exp_strobe(code) + exp_hold(code)) * q : 0),
          {req, " R7 data_oe clocks"}, n_doe, we ? (exp_strobe(code) + exp_hold(code)) * q : 0);
    check(bad == 0, {req, " R6 strobe kind/busy"}, bad, 0);
    check(addr_o == a && wdata_o == d, {req, " R8 captured addr/data"},
          {addr_o, wdata_o}, {a, d});
    @(negedge clk);
    check(!done_o && !busy_o, {req, " R9 single done pulse"}, {done_o, busy_o}, 0);
    if (interfere)
      check(addr_o == a, {req, " R10 busy request ignored"}, addr_o, a);
  endtask

  task automatic t_reset;
    check({busy_o, done_o, ale_o, rd_o, wr_o, addr_oe_o, data_oe_o} == '0 &&
          addr_o == '0 && wdata_o == '0, "R11 reset outputs",
          {busy_o, done_o, ale_o, rd_o, wr_o, addr_oe_o, data_oe_o}, 0);
  endtask

  task automatic t_no_stretch;
    access(0, 0, 1'b0, 1'b0, 16'h1234, 8'h00, 1'b0, "R1 m0 read");
    access(0, 1, 1'b0, 1'b1, 16'h2345, 8'hA5, 1'b0, "R1 m1 write");
    access(0, 2, 1'b0, 1'b0, 16'h3456, 8'h00, 1'b0, "R1 m2 read");
  endtask

  task automatic t_short_stretch;
    for (int c = 1; c <= 3; c++)
      access(c, 0, 1'b0, 1'b1, 16'h4000 + 16'(c), 8'h10 + 8'(c), 1'b0, "R2 write miss");
    access(2, 1, 1'b1, 1'b0, 16'h4100, 8'h00, 1'b0, "R2 read hit m1");
  endtask

  task automatic t_long_stretch;
    for (int c = 4; c <= 7; c++)
      access(c, 0, 1'b0, c[0], 16'h5000 + 16'(c), 8'h20 + 8'(c), 1'b0, "R3 miss");
    access(6, 0, 1'b1, 1'b1, 16'h5100, 8'h3C, 1'b0, "R3 write hit");
  endtask

  task automatic t_busy_ignore;
    access(5, 1, 1'b0, 1'b1, 16'h6A6A, 8'h5A, 1'b1, "R10 long");
    access(0, 0, 1'b1, 1'b0, 16'h6B6B, 8'h00, 1'b1, "R10 short hit");
  endtask

  task automatic t_slow_tick;
    access(0, 3, 1'b1, 1'b0, 16'h7000, 8'h00, 1'b0, "R5 slow tick");
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_no_stretch();
    t_short_stretch();
    t_long_stretch();
    t_busy_ignore();
    t_slow_tick();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule